// File: doc/BRIEF.md
# Multi-Channel DAC Code Latch with Synchronous Load

This block holds, for each of several DAC channels, a data register and an output latch that drives the converter code. Each channel has its own mode input. A channel in immediate mode copies a written code straight to its output latch. A channel in synchronous mode only stores the code and marks itself pending. The output stays where it was until a global load is requested.

A load request raises a one-cycle load flag that clears itself. In the cycle the flag is high, every pending channel moves its data register into its latch. Channels with nothing pending keep their latch untouched, so their outputs do not glitch. Several outputs can therefore be retargeted at the same instant while the others stay quiet.

Top module: `dac_sync_latch`

## Requirements
- R1: Reset (rst_n low) clears every data register, every output latch, the pending vector and load_flag to 0.
- R2: A write (wr_en high, wr_addr selecting channel i) to a channel whose sync_mode[i] is 0 makes dac_codes[i*DW +: DW] equal wr_data from the next cycle.
- R3: A write to a channel whose sync_mode[i] is 1 leaves that channel's output unchanged while load_flag is low, and sets pending[i] from the next cycle.
- R4: load_req high in a cycle makes load_flag high in the next cycle. load_flag then returns to 0 one cycle later unless load_req is high again.
- R5: In a cycle with load_flag high, every channel with pending[i] set copies its data register to its output latch. The new code is visible in the next cycle, when pending[i] is 0 (unless R7 applies).
- R6: A channel whose pending bit is 0 keeps its output code unchanged across a load.
- R7: A synchronous-mode write in the same cycle that load_flag is high is not applied by that load. The channel stays pending with the new value. If the channel was already pending, its latch takes the value written before.
- R8: A write to an immediate-mode channel clears that channel's pending bit, even if an earlier synchronous write had set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Data register write strobe |
| wr_addr | input | AW | Channel selected by the write |
| wr_data | input | DW | Code written |
| sync_mode | input | NCH | Per-channel mode, 1 = synchronous, 0 = immediate |
| load_req | input | 1 | Sets the self-clearing load flag |
| load_flag | output | 1 | Load flag; a transfer happens in the cycle it is high |
| pending | output | NCH | Per-channel written-since-last-load marks |
| dac_codes | output | NCH*DW | Output latches, channel i at bits [i*DW +: DW] |

## Verification
A lost or stuck pending bit shows up at the ports within two cycles of the next load request. A channel that should have moved keeps its old code, or an untouched channel changes code. A data register that loses a value is only seen when its channel is next loaded, so the tests always follow a write with a load and compare the code. A write landing on the transfer cycle is the narrowest case. A wrong priority there appears one cycle after the flag, as a code that moved too early or a pending bit that dropped.

// File: rtl/dac_sync_latch.sv
module dac_sync_latch #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NCH-1:0]    sync_mode,
  input  logic              load_req,
  output logic              load_flag,
  output logic [NCH-1:0]    pending,
  output logic [NCH*DW-1:0] dac_codes
);

  logic ld_q;
  logic [NCH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ld_q <= 1'b0;
    else        ld_q <= load_req;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] data_q;
    logic [DW-1:0] latch_q;
    wire hit = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q    <= '0;
        latch_q   <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (hit) data_q <= wr_data;
        if (hit && !sync_mode[i])        latch_q <= wr_data;
        else if (ld_q && pend_q[i])      latch_q <= data_q;
        if (hit)       pend_q[i] <= sync_mode[i];
        else if (ld_q) pend_q[i] <= 1'b0;
      end
    end

    assign dac_codes[i*DW +: DW] = latch_q;
  end

  assign load_flag = ld_q;
  assign pending   = pend_q;

endmodule

module dac_sync_latch_chk #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [NCH-1:0]    sync_mode,
  input logic              load_req,
  input logic              load_flag,
  input logic [NCH-1:0]    pending,
  input logic [NCH*DW-1:0] dac_codes
);

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> load_flag);
  a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load_flag && !load_req) |=> !load_flag);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    wire hit = wr_en && (wr_addr == AW'(i));

    a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !sync_mode[i]) |=> (dac_codes[i*DW +: DW] == $past(wr_data)));
    a_r8_imm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !sync_mode[i]) |=> !pending[i]);
    a_r3_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sync_mode[i] && !load_flag) |=> ($stable(dac_codes[i*DW +: DW]) && pending[i]));
    a_r5_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (load_flag && pending[i] && !hit) |=> !pending[i]);
    a_r6_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (load_flag && !pending[i] && !hit) |=> $stable(dac_codes[i*DW +: DW]));
    a_r7_kept_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (load_flag && hit && sync_mode[i]) |=> pending[i]);
  end

endmodule

bind dac_sync_latch dac_sync_latch_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/tb_dac_sync_latch.sv
module tb_dac_sync_latch;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int AW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NCH-1:0] sync_mode = '0;
  logic load_req = 1'b0;
  logic load_flag;
  logic [NCH-1:0] pending;
  logic [NCH*DW-1:0] dac_codes;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dac_sync_latch #(.NCH(NCH), .DW(DW)) dut (.*);

  // {wr, ld, mode, addr, data, chk_ch, exp_code, exp_pend, exp_flag}
  localparam int VW = 39;
  localparam int NV = 19;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,1'b0,4'hC,2'd0,12'h123, 2'd0,12'h123,4'h0,1'b0}, // R2
    {1'b1,1'b0,4'hC,2'd2,12'h456, 2'd2,12'h000,4'h4,1'b0}, // R3
    {1'b1,1'b0,4'hC,2'd3,12'h789, 2'd3,12'h000,4'hC,1'b0}, // R3
    {1'b0,1'b1,4'hC,2'd0,12'h000, 2'd2,12'h000,4'hC,1'b1}, // R4 set
    {1'b0,1'b0,4'hC,2'd0,12'h000, 2'd2,12'h456,4'h0,1'b0}, // R5 R4 clear
    {1'b0,1'b0,4'hC,2'd0,12'h000, 2'd3,12'h789,4'h0,1'b0}, // R5
    {1'b1,1'b0,4'hC,2'd2,12'hABC, 2'd2,12'h456,4'h4,1'b0}, // R3
    {1'b0,1'b1,4'hC,2'd0,12'h000, 2'd2,12'h456,4'h4,1'b1}, // R4
    {1'b1,1'b0,4'hC,2'd3,12'h111, 2'd3,12'h789,4'h8,1'b0}, // R7
    {1'b0,1'b0,4'hC,2'd0,12'h000, 2'd2,12'hABC,4'h8,1'b0}, // R5
    {1'b0,1'b1,4'hC,2'd0,12'h000, 2'd3,12'h789,4'h8,1'b1}, // R4
    {1'b0,1'b0,4'hC,2'd0,12'h000, 2'd3,12'h111,4'h0,1'b0}, // R5
    {1'b0,1'b1,4'hC,2'd0,12'h000, 2'd0,12'h123,4'h0,1'b1}, // R6
    {1'b0,1'b0,4'hC,2'd0,12'h000, 2'd3,12'h111,4'h0,1'b0}, // R6
    {1'b1,1'b0,4'hC,2'd3,12'h222, 2'd3,12'h111,4'h8,1'b0}, // R3
    {1'b1,1'b0,4'h0,2'd3,12'h333, 2'd3,12'h333,4'h0,1'b0}, // R8
    {1'b1,1'b0,4'h0,2'd1,12'h0FF, 2'd1,12'h0FF,4'h0,1'b0}, // R2
    {1'b0,1'b1,4'h0,2'd0,12'h000, 2'd1,12'h0FF,4'h0,1'b1}, // R6
    {1'b0,1'b0,4'h0,2'd0,12'h000, 2'd3,12'h333,4'h0,1'b0}  // R6
  };

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int code_of(input int ch);
    return int'(dac_codes[ch*DW +: DW]);
  endfunction

  task automatic step(input logic w, input logic l, input logic [3:0] m,
                      input logic [1:0] a, input logic [11:0] d);
    wr_en = w; load_req = l; sync_mode = m; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; load_req = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCH; c++) check("R1 code", code_of(c), 0);
    check("R1 pending", int'(pending), 0);
    check("R1 flag", int'(load_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      step(v[38], v[37], v[36:33], v[32:31], v[30:19]);
      check($sformatf("table step %0d code", k), code_of(int'(v[18:17])), int'(v[16:5]));
      check($sformatf("table step %0d pending", k), int'(pending), int'(v[4:1]));
      check($sformatf("table step %0d flag", k), int'(load_flag), int'(v[0]));
    end

    // R7: channel already pending, rewritten on the transfer cycle
    step(1'b1, 1'b0, 4'h4, 2'd2, 12'h5A5);
    step(1'b0, 1'b1, 4'h4, 2'd0, 12'h000);
    step(1'b1, 1'b0, 4'h4, 2'd2, 12'h6B6);
    check("R7 older value loaded", code_of(2), 12'h5A5);
    check("R7 still pending", int'(pending[2]), 1);
    step(1'b0, 1'b1, 4'h4, 2'd0, 12'h000);
    check("R7 held until load", code_of(2), 12'h5A5);
    step(1'b0, 1'b0, 4'h4, 2'd0, 12'h000);
    check("R7 newer value loaded", code_of(2), 12'h6B6);
    check("R5 pending cleared", int'(pending), 0);

    // R4: load request held two cycles keeps the flag high
    step(1'b0, 1'b1, 4'h4, 2'd0, 12'h000);
    step(1'b0, 1'b1, 4'h4, 2'd0, 12'h000);
    check("R4 flag held", int'(load_flag), 1);
    step(1'b0, 1'b0, 4'h4, 2'd0, 12'h000);
    check("R4 flag cleared", int'(load_flag), 0);

    // R1 mid-run reset
    step(1'b1, 1'b0, 4'h4, 2'd2, 12'h777);
    rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R1 code after reset", code_of(c), 0);
    check("R1 pending after reset", int'(pending), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule